// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block holds the 13-bit instruction address of a small Harvard-architecture controller core and keeps the return addresses for subroutine calls and interrupts. On each instruction-cycle strobe it moves to the next address, loads a branch target, enters a subroutine or the interrupt handler, or resumes from the most recent saved address. Without the strobe it holds its state.

The address space is 8K words, but the program store that is actually built holds only 512, 1K or 2K words. A parameter selects the size. The fetch address sent to the store keeps only the low 9, 10 or 11 bits, so any higher address wraps into the built range. The return stack is a circular buffer of eight entries. It reports its fill level and its full and empty states so the surrounding core and the testbench can observe it.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address is set to 0x0000, the stack fill level to 0, `stk_empty` to 1 and `stk_full` to 0.
- R2: When `adv` is high and no control input is high, the address increases by one. When `adv` is low, neither the address nor the stack changes, whatever the control inputs are.
- R3: `adv` together with `br_jump` (and no higher-priority control) loads the address from `br_target`.
- R4: `adv` together with `br_call` (and no higher-priority control) saves the current address plus one on the stack and loads `br_target`.
- R5: `adv` together with `irq_take` saves the current address plus one on the stack and loads the fixed handler address 0x0004.
- R6: `adv` together with `br_ret` (and no `irq_take`) loads the address from the most recent stack entry and removes that entry.
- R7: When several controls are high in the same cycle, the priority is `irq_take` first, then `br_ret`, then `br_call`, then `br_jump`.
- R8: `fetch_addr` carries the low log2(MEM_WORDS) bits of the 13-bit address, with its upper bits zero. Stepping from 0x1FFF wraps the address to 0x0000.
- R9: A ninth save without any removal overwrites the oldest entry. No error is flagged. The fill level saturates at 8, and `stk_full` is 1 while the level is 8.
- R10: A removal from an empty stack loads whatever value is held in the slot below the write position. The fill level stays at 0 and `stk_empty` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv | input | 1 | Instruction-cycle strobe; all updates happen only when it is high |
| br_jump | input | 1 | Load the branch target |
| br_call | input | 1 | Save the return address and load the branch target |
| br_ret | input | 1 | Resume from the most recent saved address |
| irq_take | input | 1 | Save the return address and go to the handler at 0x0004 |
| br_target | input | 13 | Branch or call target address |
| fetch_addr | output | 13 | Address folded onto the built program store |
| stk_level | output | 4 | Number of valid stack entries (0 to 8) |
| stk_full | output | 1 | The stack holds eight entries |
| stk_empty | output | 1 | The stack holds no entries |

## Verification
The vector table walks through these patterns:
- plain steps;
- jumps and calls to targets inside and above the built range, which shows whether the address is folded;
- calls nested inside an interrupt, which shows the last-in, first-out order on return;
- cycles with all controls high, or with several combined, which separate the four priority levels;
- a cycle with controls but no strobe, which shows that the strobe gates every update.

Directed runs make nine calls and then nine returns. These tell apart a stack that saturates and overwrites its oldest entry from one that blocks or corrupts. The final return, from the empty stack, reads back the value of the slot that was overwritten.

// File: rtl/prog_seq_pkg.sv
// Package: shared operation encoding and fixed vectors for the address sequencer.
// Assumes a single operation is chosen per instruction cycle.
package prog_seq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_STEP = 3'd1,
        OP_JUMP = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_IRQ  = 3'd5
    } seq_op_e;

    localparam int RESET_VECTOR = 0;
    localparam int IRQ_VECTOR   = 4;

endpackage

// File: rtl/seq_op_sel.sv
// Module: seq_op_sel
// Chooses one operation per cycle from the control inputs by fixed priority:
// interrupt, return, call, jump, then plain step. Assumes that a cycle
// without the strobe changes nothing.
module seq_op_sel
    import prog_seq_pkg::*;
(
    input  logic    adv,
    input  logic    irq_take,
    input  logic    br_ret,
    input  logic    br_call,
    input  logic    br_jump,
    output seq_op_e op
);

    // Priority encode the control inputs into one operation
    always_comb begin
        if (!adv)          op = OP_HOLD;
        else if (irq_take) op = OP_IRQ;
        else if (br_ret)   op = OP_RET;
        else if (br_call)  op = OP_CALL;
        else if (br_jump)  op = OP_JUMP;
        else               op = OP_STEP;
    end

endmodule

// File: rtl/ret_stack.sv
// Module: ret_stack
// Circular return-address stack. A save writes at the pointer and advances it.
// A removal steps the pointer back. The top output always shows the slot below
// the pointer. The fill level saturates at DEPTH and at 0, and overflow or
// underflow is never flagged. Assumes save and removal are never requested
// in the same cycle.
module ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               push_data,
    output logic [W-1:0]               top_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign rd_ptr   = wr_ptr - 1'b1;
    assign top_data = slot[rd_ptr];
    assign full     = (level == LVL_MAX);
    assign empty    = (level == '0);

    // Slot storage: clear on reset, write at the pointer on a save
    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[gi] <= '0;
                else if (push && (wr_ptr == PTR_W'(gi)))
                    slot[gi] <= push_data;
            end
        end
    endgenerate

    // Circular write pointer: wraps in both directions
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (push) wr_ptr <= wr_ptr + 1'b1;
        else if (pop)  wr_ptr <= rd_ptr;
    end

    // Fill level: saturates at DEPTH and at zero
    always_ff @(posedge clk) begin
        if (!rst_n)               level <= '0;
        else if (push && !full)   level <= level + 1'b1;
        else if (pop  && !empty)  level <= level - 1'b1;
    end

endmodule

// File: rtl/prog_seq.sv
// Module: prog_seq
// Instruction address sequencer. It holds the 13-bit address, chooses the next
// address from the selected operation, saves return addresses on a call or an
// interrupt, and folds the address onto the built program store of MEM_WORDS
// words. Assumes MEM_WORDS is a power of two no larger than 2**ADDR_W.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int STACK_DEPTH = 8,
    parameter int MEM_WORDS   = 2048
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             adv,
    input  logic                             br_jump,
    input  logic                             br_call,
    input  logic                             br_ret,
    input  logic                             irq_take,
    input  logic [ADDR_W-1:0]                br_target,
    output logic [ADDR_W-1:0]                fetch_addr,
    output logic [$clog2(STACK_DEPTH+1)-1:0] stk_level,
    output logic                             stk_full,
    output logic                             stk_empty
);

    localparam int IMPL_W = $clog2(MEM_WORDS);

    seq_op_e           op;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] ret_addr;
    logic              do_push;
    logic              do_pop;

    seq_op_sel u_sel (
        .adv      (adv),
        .irq_take (irq_take),
        .br_ret   (br_ret),
        .br_call  (br_call),
        .br_jump  (br_jump),
        .op       (op)
    );

    assign pc_inc  = pc + 1'b1;
    assign do_push = (op == OP_CALL) || (op == OP_IRQ);
    assign do_pop  = (op == OP_RET);

    ret_stack #(
        .W     (ADDR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc),
        .top_data  (ret_addr),
        .level     (stk_level),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    // Next-address select for the chosen operation
    always_comb begin
        case (op)
            OP_STEP: pc_nxt = pc_inc;
            OP_JUMP: pc_nxt = br_target;
            OP_CALL: pc_nxt = br_target;
            OP_RET:  pc_nxt = ret_addr;
            OP_IRQ:  pc_nxt = ADDR_W'(IRQ_VECTOR);
            default: pc_nxt = pc;
        endcase
    end

    // Address register: reset vector, then the selected next address
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= ADDR_W'(RESET_VECTOR);
        else        pc <= pc_nxt;
    end

    // Fold onto the built store when it is smaller than the address space
    generate
        if (IMPL_W < ADDR_W) begin : g_fold
            assign fetch_addr = {{(ADDR_W-IMPL_W){1'b0}}, pc[IMPL_W-1:0]};
        end else begin : g_full
            assign fetch_addr = pc;
        end
    endgenerate

endmodule

// File: rtl/prog_seq_chk.sv
// Module: prog_seq_chk
// Property checker for prog_seq, attached with bind. It watches only the ports.
module prog_seq_chk #(
    parameter int ADDR_W      = 13,
    parameter int STACK_DEPTH = 8,
    parameter int MEM_WORDS   = 2048
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             adv,
    input logic                             br_jump,
    input logic                             br_call,
    input logic                             br_ret,
    input logic                             irq_take,
    input logic [ADDR_W-1:0]                br_target,
    input logic [ADDR_W-1:0]                fetch_addr,
    input logic [$clog2(STACK_DEPTH+1)-1:0] stk_level,
    input logic                             stk_full,
    input logic                             stk_empty
);

    localparam int IMPL_W = $clog2(MEM_WORDS);
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(MEM_WORDS - 1);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0) && (stk_level == '0) && stk_empty && !stk_full);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(fetch_addr) && $stable(stk_level));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !irq_take && !br_ret && !br_call && !br_jump
        |=> fetch_addr == (($past(fetch_addr) + 1'b1) & MASK));

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv && br_jump && !irq_take && !br_ret && !br_call
        |=> fetch_addr == ($past(br_target) & MASK));

    assert_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv && br_call && !irq_take && !br_ret
        |=> (fetch_addr == ($past(br_target) & MASK)) && !stk_empty);

    assert_irq_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv && irq_take |=> (fetch_addr == ADDR_W'(4)) && !stk_empty);

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr >> IMPL_W) == '0);

    assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv && br_call && !irq_take && !br_ret && stk_full |=> stk_full);

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adv && br_ret && !irq_take && stk_empty |=> stk_empty);

endmodule

bind prog_seq prog_seq_chk #(
    .ADDR_W      (ADDR_W),
    .STACK_DEPTH (STACK_DEPTH),
    .MEM_WORDS   (MEM_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .br_jump    (br_jump),
    .br_call    (br_call),
    .br_ret     (br_ret),
    .irq_take   (irq_take),
    .br_target  (br_target),
    .fetch_addr (fetch_addr),
    .stk_level  (stk_level),
    .stk_full   (stk_full),
    .stk_empty  (stk_empty)
);

// File: tb/sim_prog_seq.sv
// Testbench for prog_seq: a table of vectors walked by one loop, followed by
// directed tests for reset, stack overflow and removal from an empty stack.
module sim_prog_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic        br_jump = 1'b0;
    logic        br_call = 1'b0;
    logic        br_ret = 1'b0;
    logic        irq_take = 1'b0;
    logic [12:0] br_target = '0;
    logic [12:0] fetch_addr;
    logic [3:0]  stk_level;
    logic        stk_full;
    logic        stk_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prog_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .br_jump    (br_jump),
        .br_call    (br_call),
        .br_ret     (br_ret),
        .irq_take   (irq_take),
        .br_target  (br_target),
        .fetch_addr (fetch_addr),
        .stk_level  (stk_level),
        .stk_full   (stk_full),
        .stk_empty  (stk_empty)
    );

    // Vector layout: {adv, irq, ret, call, jump, target, expected fetch, expected level}
    localparam logic [34:0] VEC [19] = '{
        {5'b10000, 13'h0000, 13'h0001, 4'd0},  // R2 step
        {5'b10000, 13'h0000, 13'h0002, 4'd0},  // R2 step
        {5'b10001, 13'h0100, 13'h0100, 4'd0},  // R3 jump
        {5'b10010, 13'h0200, 13'h0200, 4'd1},  // R4 call, saves 0x101
        {5'b10000, 13'h0000, 13'h0201, 4'd1},  // R2
        {5'b11000, 13'h0000, 13'h0004, 4'd2},  // R5 irq, saves 0x202
        {5'b10000, 13'h0000, 13'h0005, 4'd2},  // R2
        {5'b10100, 13'h0000, 13'h0202, 4'd1},  // R6 return
        {5'b10100, 13'h0000, 13'h0101, 4'd0},  // R6 return
        {5'b10001, 13'h1F05, 13'h0705, 4'd0},  // R8 folded jump
        {5'b10010, 13'h0010, 13'h0010, 4'd1},  // R4 saves 0x1F06
        {5'b10100, 13'h0000, 13'h0706, 4'd0},  // R6 R8 full address kept
        {5'b00001, 13'h0333, 13'h0706, 4'd0},  // R2 no strobe, no change
        {5'b11111, 13'h0555, 13'h0004, 4'd1},  // R7 irq wins, saves 0x1F07
        {5'b10110, 13'h0123, 13'h0707, 4'd0},  // R7 ret beats call
        {5'b10011, 13'h0050, 13'h0050, 4'd1},  // R7 call beats jump, saves 0x1F08
        {5'b10100, 13'h0000, 13'h0708, 4'd0},  // R6
        {5'b10001, 13'h1FFF, 13'h07FF, 4'd0},  // R8
        {5'b10000, 13'h0000, 13'h0000, 4'd0}   // R8 wrap from 0x1FFF
    };

    // Record one comparison and report a mismatch
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of controls, then clear them and sample after the edge
    task automatic cyc(input logic [4:0] c, input logic [12:0] t);
        @(negedge clk);
        {adv, irq_take, br_ret, br_call, br_jump} = c;
        br_target = t;
        @(negedge clk);
        {adv, irq_take, br_ret, br_call, br_jump} = 5'b0;
        br_target = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 fetch", int'(fetch_addr), 0);
        chk("R1 level", int'(stk_level), 0);
        chk("R1 empty", int'(stk_empty), 1);
        chk("R1 full", int'(stk_full), 0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        for (int i = 0; i < 19; i++) begin
            cyc(VEC[i][34:30], VEC[i][29:17]);
            chk($sformatf("vec%0d fetch R2-R8", i), int'(fetch_addr), int'(VEC[i][16:4]));
            chk($sformatf("vec%0d level", i), int'(stk_level), int'(VEC[i][3:0]));
        end

        // R9: nine calls; call k saves (k-1)*0x10+1
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            cyc(5'b10010, 13'(k * 16));
            if (k == 8) begin
                chk("R9 level at 8", int'(stk_level), 8);
                chk("R9 full at 8", int'(stk_full), 1);
            end
        end
        chk("R9 level saturated", int'(stk_level), 8);
        chk("R9 full", int'(stk_full), 1);
        chk("R4 last target", int'(fetch_addr), 'h90);
        for (int k = 9; k >= 2; k--) begin
            cyc(5'b10100, 13'h0);
            chk($sformatf("R9 pop entry %0d", k), int'(fetch_addr), (k - 1) * 16 + 1);
        end
        chk("R9 level drained", int'(stk_level), 0);
        chk("R10 empty", int'(stk_empty), 1);

        // R10: removal from empty reads the overwritten slot (0x81)
        cyc(5'b10100, 13'h0);
        chk("R10 empty pop value", int'(fetch_addr), 'h81);
        chk("R10 level stays 0", int'(stk_level), 0);
        chk("R10 still empty", int'(stk_empty), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule